// File: doc/BRIEF.md
# BCD Alarm Time Setter

This block is the alarm section of a digital clock. It keeps an alarm time as four BCD digits (hour tens, hour units, minute tens, minute units) and lets a user adjust it with three buttons. A set button cycles a mode register through idle, hour edit and minute edit. In the two edit modes, the up and down buttons step the selected field by one, wrapping at the ends of its range. The field is stored and stepped in BCD, so no binary-to-decimal conversion is needed.

All buttons are sampled on the system clock and turned into single-cycle pulses on their rising edges. They are never used as clocks. A buzzer output is combinational: it is high when the alarm is armed and the four stored digits equal the current-time BCD digits presented on the inputs. Debouncing, timekeeping and display drive are done elsewhere.

Top module: `bcd_alarm_setter`

## Requirements
- R1: Asynchronous active-low reset sets the mode to idle (mode_o = 2'd0) and the alarm time to 00:00.
- R2: Each rising edge of set_i, found by comparing the sampled value with the value one clock earlier, advances mode_o by one step: idle (0) to hour edit (1), then to minute edit (2), then back to idle (0). Holding set_i high gives only one advance.
- R3: In hour edit, a rising edge of up_i adds one hour. From 23 it wraps to 00.
- R4: In hour edit, a rising edge of down_i subtracts one hour. From 00 it wraps to 23.
- R5: In minute edit, a rising edge of up_i adds one minute. From 59 it wraps to 00.
- R6: In minute edit, a rising edge of down_i subtracts one minute. From 00 it wraps to 59.
- R7: Stepping is in BCD. The units digit carries into the tens digit after 9 and borrows from it below 0. Each digit is 4 bits on the alarm outputs.
- R8: In idle, up_i and down_i edges leave the alarm time unchanged.
- R9: If up_i and down_i rise in the same cycle, only the increment is applied.
- R10: buzz_o is high exactly when arm_i is high and all four stored digits equal the four current-time digits.
- R11: Each button edge changes the stored state on the clock edge after the edge is sampled. This gives a two-edge latency from the input change, because of one sample register and one state register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| set_i | input | 1 | Mode step button (level) |
| up_i | input | 1 | Increment button (level) |
| down_i | input | 1 | Decrement button (level) |
| arm_i | input | 1 | Alarm enable |
| now_hr_tens_i | input | 4 | Current hour tens digit |
| now_hr_ones_i | input | 4 | Current hour units digit |
| now_mn_tens_i | input | 4 | Current minute tens digit |
| now_mn_ones_i | input | 4 | Current minute units digit |
| mode_o | output | 2 | 0 idle, 1 hour edit, 2 minute edit |
| alm_hr_tens_o | output | 4 | Stored hour tens digit |
| alm_hr_ones_o | output | 4 | Stored hour units digit |
| alm_mn_tens_o | output | 4 | Stored minute tens digit |
| alm_mn_ones_o | output | 4 | Stored minute units digit |
| buzz_o | output | 1 | Alarm match |

## Verification
The bench walks every hour from 00 to 23 and every minute from 00 to 59, in both directions. Each step is compared with a value computed arithmetically and split into digits.

Several faults are aimed at directly:
- A carry or borrow slip shows up at 09 to 10 and 10 to 09, where a faulty design would produce 0A or 0F.
- A wrong wrap point shows up at 23/00 and 59/00, where a faulty design would reach 24 or 60.

Held buttons are checked to confirm they step only once. Up and down pressed together must pick increment. Presses in idle must leave the time alone.

The buzzer is checked against matches and against a mismatch in each single digit, with arm_i both high and low.

// File: rtl/bcd_alarm_pkg.sv
package bcd_alarm_pkg;
  localparam int unsigned DIGIT_W = 4;
  typedef logic [DIGIT_W-1:0] digit_t;
  typedef enum logic [1:0] {
    MODE_IDLE = 2'd0,
    MODE_HOUR = 2'd1,
    MODE_MIN  = 2'd2
  } mode_e;
  typedef struct packed {
    digit_t tens;
    digit_t ones;
  } bcd2_t;
endpackage

// File: rtl/bcd_edge_detect.sv
module bcd_edge_detect #(
  parameter int unsigned N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] lvl_i,
  output logic [N-1:0] rise_o
);
  logic [N-1:0] cur_q, prev_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q  <= '0;
      prev_q <= '0;
    end else begin
      cur_q  <= lvl_i;
      prev_q <= cur_q;
    end
  end
  assign rise_o = cur_q & ~prev_q;
endmodule

// File: rtl/bcd_field_step.sv
module bcd_field_step
  import bcd_alarm_pkg::*;
#(
  parameter int unsigned MAX_TENS = 2,
  parameter int unsigned MAX_ONES = 3
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  en_i,
  input  logic  inc_i,
  input  logic  dec_i,
  output bcd2_t val_o
);
  localparam digit_t TOP_T = digit_t'(MAX_TENS);
  localparam digit_t TOP_O = digit_t'(MAX_ONES);

  bcd2_t val_q, nxt;

  always_comb begin
    nxt = val_q;
    if (en_i && inc_i) begin
      if (val_q.tens == TOP_T && val_q.ones == TOP_O) begin
        nxt = '0;
      end else if (val_q.ones == digit_t'(9)) begin
        nxt.ones = '0;
        nxt.tens = val_q.tens + digit_t'(1);
      end else begin
        nxt.ones = val_q.ones + digit_t'(1);
      end
    end else if (en_i && dec_i) begin
      if (val_q.tens == '0 && val_q.ones == '0) begin
        nxt.tens = TOP_T;
        nxt.ones = TOP_O;
      end else if (val_q.ones == '0) begin
        nxt.ones = digit_t'(9);
        nxt.tens = val_q.tens - digit_t'(1);
      end else begin
        nxt.ones = val_q.ones - digit_t'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) val_q <= '0;
    else         val_q <= nxt;
  end

  assign val_o = val_q;
endmodule

// File: rtl/bcd_alarm_setter.sv
module bcd_alarm_setter
  import bcd_alarm_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       set_i,
  input  logic       up_i,
  input  logic       down_i,
  input  logic       arm_i,
  input  logic [3:0] now_hr_tens_i,
  input  logic [3:0] now_hr_ones_i,
  input  logic [3:0] now_mn_tens_i,
  input  logic [3:0] now_mn_ones_i,
  output logic [1:0] mode_o,
  output logic [3:0] alm_hr_tens_o,
  output logic [3:0] alm_hr_ones_o,
  output logic [3:0] alm_mn_tens_o,
  output logic [3:0] alm_mn_ones_o,
  output logic       buzz_o
);
  localparam int unsigned NBTN = 3;

  logic [NBTN-1:0] rise;
  logic            set_p, up_p, dn_p;
  mode_e           mode_q, mode_d;
  bcd2_t           hr, mn;

  bcd_edge_detect #(.N(NBTN)) u_edges (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  ({down_i, up_i, set_i}),
    .rise_o (rise)
  );
  assign set_p = rise[0];
  assign up_p  = rise[1];
  assign dn_p  = rise[2];

  always_comb begin
    mode_d = mode_q;
    if (set_p) begin
      unique case (mode_q)
        MODE_IDLE: mode_d = MODE_HOUR;
        MODE_HOUR: mode_d = MODE_MIN;
        default:   mode_d = MODE_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= MODE_IDLE;
    else         mode_q <= mode_d;
  end

  // increment has priority inside the stepper
  bcd_field_step #(.MAX_TENS(2), .MAX_ONES(3)) u_hour (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (mode_q == MODE_HOUR),
    .inc_i  (up_p),
    .dec_i  (dn_p),
    .val_o  (hr)
  );

  bcd_field_step #(.MAX_TENS(5), .MAX_ONES(9)) u_min (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (mode_q == MODE_MIN),
    .inc_i  (up_p),
    .dec_i  (dn_p),
    .val_o  (mn)
  );

  assign mode_o        = mode_q;
  assign alm_hr_tens_o = hr.tens;
  assign alm_hr_ones_o = hr.ones;
  assign alm_mn_tens_o = mn.tens;
  assign alm_mn_ones_o = mn.ones;

  assign buzz_o = arm_i &&
                  hr.tens == now_hr_tens_i && hr.ones == now_hr_ones_i &&
                  mn.tens == now_mn_tens_i && mn.ones == now_mn_ones_i;
endmodule

// File: rtl/bcd_alarm_setter_chk.sv
module bcd_alarm_setter_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] mode_o,
  input logic [3:0] alm_hr_tens_o,
  input logic [3:0] alm_hr_ones_o,
  input logic [3:0] alm_mn_tens_o,
  input logic [3:0] alm_mn_ones_o
);
  // R2
  p_mode_legal_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o != 2'd3);
  p_mode_seq_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o != $past(mode_o) |-> mode_o == (($past(mode_o) == 2'd2) ? 2'd0 : $past(mode_o) + 2'd1));
  // R3 / R4
  p_hour_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alm_hr_tens_o < 4'd2 && alm_hr_ones_o <= 4'd9) || (alm_hr_tens_o == 4'd2 && alm_hr_ones_o <= 4'd3));
  // R5 / R6
  p_min_range_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alm_mn_tens_o <= 4'd5 && alm_mn_ones_o <= 4'd9);
  // R8
  p_idle_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(mode_o) == 2'd0 |-> $stable(alm_hr_tens_o) && $stable(alm_hr_ones_o)
                             && $stable(alm_mn_tens_o) && $stable(alm_mn_ones_o));
  p_hour_hold_min_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(mode_o) != 2'd1 |-> $stable(alm_hr_tens_o) && $stable(alm_hr_ones_o));
endmodule

bind bcd_alarm_setter bcd_alarm_setter_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .mode_o        (mode_o),
  .alm_hr_tens_o (alm_hr_tens_o),
  .alm_hr_ones_o (alm_hr_ones_o),
  .alm_mn_tens_o (alm_mn_tens_o),
  .alm_mn_ones_o (alm_mn_ones_o)
);

// File: tb/bcd_alarm_setter_tb.sv
module bcd_alarm_setter_tb;
  localparam time CLK_PERIOD = 10ns;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic set_i = 0, up_i = 0, down_i = 0, arm_i = 0;
  logic [3:0] nht = 0, nho = 0, nmt = 0, nmo = 0;
  logic [1:0] mode_o;
  logic [3:0] aht, aho, amt, amo;
  logic buzz_o;
  int n_run = 0, n_fail = 0;
  int exp_h = 0, exp_m = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  bcd_alarm_setter u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(set_i), .up_i(up_i), .down_i(down_i),
    .arm_i(arm_i), .now_hr_tens_i(nht), .now_hr_ones_i(nho),
    .now_mn_tens_i(nmt), .now_mn_ones_i(nmo), .mode_o(mode_o),
    .alm_hr_tens_o(aht), .alm_hr_ones_o(aho), .alm_mn_tens_o(amt),
    .alm_mn_ones_o(amo), .buzz_o(buzz_o)
  );

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // drive on negedge, wait enough edges for sample + state registers
  task automatic tick(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic press(input int which, input bit both);
    if (which == 0) set_i = 1; else if (which == 1) up_i = 1; else down_i = 1;
    if (both) begin up_i = 1; down_i = 1; end
    tick(1);
    set_i = 0; up_i = 0; down_i = 0;
    tick(3);
  endtask

  function automatic int hval();
    return aht * 10 + aho;
  endfunction
  function automatic int mval();
    return amt * 10 + amo;
  endfunction

  task automatic chk_time(input string req);
    check(req, hval(), exp_h);
    check(req, mval(), exp_m);
    check({req, "_digits"}, int'(aho <= 9 && amo <= 9), 1);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    tick(1);
    check("R1 mode", mode_o, 0);
    chk_time("R1");
    rst_ni = 1;
    tick(2);

    // R8 idle presses ignored
    press(1, 0); chk_time("R8 up idle");
    press(2, 0); chk_time("R8 down idle");

    // R11 latency: set edge changes mode after second posedge
    set_i = 1; tick(1);
    check("R11 one edge", mode_o, 0);
    tick(1);
    check("R11 two edges", mode_o, 1);
    tick(5); // held high: no further step (R2)
    check("R2 held", mode_o, 1);
    set_i = 0; tick(2);

    // hour edit: full sweep up and down, R3 R4 R7
    for (int i = 0; i < 25; i++) begin
      press(1, 0); exp_h = (exp_h + 1) % 24; chk_time("R3 R7 hour up");
    end
    for (int i = 0; i < 26; i++) begin
      press(2, 0); exp_h = (exp_h + 23) % 24; chk_time("R4 R7 hour down");
    end
    // R9 both -> increment
    press(1, 1); exp_h = (exp_h + 1) % 24; chk_time("R9 hour both");
    // held up steps once
    up_i = 1; tick(6); up_i = 0; tick(2);
    exp_h = (exp_h + 1) % 24; chk_time("R3 held");

    press(0, 0); check("R2 to minute", mode_o, 2);
    for (int i = 0; i < 61; i++) begin
      press(1, 0); exp_m = (exp_m + 1) % 60; chk_time("R5 R7 minute up");
    end
    for (int i = 0; i < 62; i++) begin
      press(2, 0); exp_m = (exp_m + 59) % 60; chk_time("R6 R7 minute down");
    end
    press(1, 1); exp_m = (exp_m + 1) % 60; chk_time("R9 minute both");
    press(0, 0); check("R2 wrap idle", mode_o, 0);
    press(1, 0); chk_time("R8 up idle late");

    // R10 buzzer
    nht = 4'(exp_h / 10); nho = 4'(exp_h % 10);
    nmt = 4'(exp_m / 10); nmo = 4'(exp_m % 10);
    arm_i = 0; #1; check("R10 disarmed", buzz_o, 0);
    arm_i = 1; #1; check("R10 match", buzz_o, 1);
    for (int d = 0; d < 4; d++) begin
      logic [3:0] s0, s1, s2, s3;
      s0 = nht; s1 = nho; s2 = nmt; s3 = nmo;
      if (d == 0) nht = nht ^ 4'd1;
      if (d == 1) nho = nho ^ 4'd1;
      if (d == 2) nmt = nmt ^ 4'd1;
      if (d == 3) nmo = nmo ^ 4'd1;
      #1; check("R10 digit mismatch", buzz_o, 0);
      nht = s0; nho = s1; nmt = s2; nmo = s3;
      #1; check("R10 rematch", buzz_o, 1);
    end

    // R1 async reset mid-run
    #2 rst_ni = 0; #1;
    exp_h = 0; exp_m = 0;
    check("R1 async mode", mode_o, 0);
    chk_time("R1 async");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule